// File: doc/BRIEF.md
# Two-Thread Issue Slot Selector

This block sits in front of a shared execution cluster that offers four issue slots per clock. Two hardware thread contexts compete for those slots. Every cycle each thread presents how many instructions it has ready, a priority weight and a stall flag. The block computes a weight for each thread as priority times ready count. It hands slots first to the heavier thread and passes any slots left over to the other one. A stalled thread is treated as having nothing ready, so its partner may fill the whole cluster. The choice is made again each cycle, so sharing is fine-grained rather than time-sliced.

Equal weights are settled by a round-robin pointer. The pointer moves only when a tie actually split the slots between both threads. The outputs are registered: a valid bit and owning thread ID for each slot, and a grant count per thread. Each thread also keeps its own program counter. The counter advances by its grant times the instruction size at the same clock edge that the grant appears. The block produces slot ownership and counts only; instruction payloads never pass through it.

Top module: `issue_slot_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, every slot valid bit, both grant counts and both program counters go to zero. The round-robin pointer is set to thread 0, so the first tie afterwards favours thread 0.
- R2: Each thread's weight is its 3-bit priority times its 3-bit ready count, kept at 6 bits so it never wraps. The thread with the strictly larger weight is preferred and receives min(ready, 4) slots.
- R3: Slots the preferred thread leaves unused go to the other thread, up to that thread's ready count. Total slots granted never exceed 4, and no thread is granted more than its ready count.
- R4: A thread whose stall flag is high receives zero slots that cycle. The other thread is then treated as sole contender and may take all 4 slots.
- R5: On equal weights the round-robin pointer names the preferred thread. The pointer toggles only in a cycle where the weights tied and both threads received at least one slot.
- R6: Slots are packed from slot 0 upward, with the preferred thread's slots first and then the other thread's. Slots beyond the total grant have valid cleared. The thread ID encoding is 0 for thread 0 and 1 for thread 1.
- R7: At the edge where a grant is made, that thread's program counter increases by grant × `INSTR_BYTES` (4 by default). With no grant, the counter holds.
- R8: All results are registered. Inputs sampled at a rising edge appear on the outputs just after that edge and do not change between edges.
- R9: When both threads are stalled or have zero ready, no slot is valid and both program counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | 2×3 | Ready instruction count per thread |
| thr_prio | input | 2×3 | Priority weight per thread |
| thr_stall | input | 2 | Stall flag per thread |
| slot_valid | output | 4 | Slot carries an instruction this cycle |
| slot_tid | output | 4 | Owning thread of each slot |
| grant_cnt | output | 2×3 | Number of slots granted per thread |
| thr_pc | output | 2×32 | Program counter per thread |

## Verification
Every result reacts one clock after its stimulus. This covers the slot map, the grant counts, each program counter and the effect of a tie on the round-robin pointer. The pointer's effect becomes visible only at the next tie. The bench drives inputs on the falling edge and samples on the following falling edge, after exactly one rising edge. It also looks once just before that rising edge to confirm that the outputs still show the previous result. Tie sequences are laid out so that each pointer move or hold is exposed by the vector that follows it.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int NUM_THREADS = 2;
  localparam int TID_W       = 1;

  typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/thread_weight.sv
module thread_weight #(
  parameter int CNT_W = 3,
  parameter int PRI_W = 3,
  localparam int WGT_W = CNT_W + PRI_W
) (
  input  logic [CNT_W-1:0] ready,
  input  logic [PRI_W-1:0] prio,
  input  logic             stall,
  output logic [CNT_W-1:0] eff_ready,
  output logic [WGT_W-1:0] weight
);
  always_comb begin
    eff_ready = stall ? '0 : ready;
    weight    = WGT_W'(eff_ready) * WGT_W'(prio);
  end
endmodule

// File: rtl/slot_split.sv
module slot_split
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 3,
  parameter int WGT_W     = 6,
  parameter int GRANT_W   = 3
) (
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] eff_ready,
  input  logic [NUM_THREADS-1:0][WGT_W-1:0] weight,
  input  tid_t                              rr_ptr,
  output tid_t                              pref,
  output logic [NUM_THREADS-1:0][GRANT_W-1:0] grant,
  output logic                              rr_toggle
);
  localparam int AW = ((CNT_W > GRANT_W) ? CNT_W : GRANT_W) + 1;

  logic          tie;
  logic [AW-1:0] want_p, want_o, take_p, left, take_o;

  always_comb begin
    tie = (weight[0] == weight[1]);
    if (tie)                        pref = rr_ptr;
    else if (weight[1] > weight[0]) pref = tid_t'(1);
    else                            pref = tid_t'(0);

    want_p = AW'(eff_ready[pref]);
    want_o = AW'(eff_ready[~pref]);
    take_p = (want_p > AW'(NUM_SLOTS)) ? AW'(NUM_SLOTS) : want_p;
    left   = AW'(NUM_SLOTS) - take_p;
    take_o = (want_o > left) ? left : want_o;

    grant         = '0;
    grant[pref]   = GRANT_W'(take_p);
    grant[~pref]  = GRANT_W'(take_o);
    rr_toggle     = tie && (take_p != '0) && (take_o != '0);
  end
endmodule

// File: rtl/slot_packer.sv
module slot_packer
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int GRANT_W   = 3
) (
  input  tid_t                 pref,
  input  logic [GRANT_W-1:0]   cnt_pref,
  input  logic [GRANT_W-1:0]   cnt_other,
  output logic [NUM_SLOTS-1:0] valid,
  output tid_t [NUM_SLOTS-1:0] tid
);
  logic [GRANT_W:0] total;
  assign total = {1'b0, cnt_pref} + {1'b0, cnt_other};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_comb begin
      valid[i] = ((GRANT_W+1)'(i) < total);
      if (!valid[i])                        tid[i] = tid_t'(0);
      else if ((GRANT_W)'(i) < cnt_pref)    tid[i] = pref;
      else                                  tid[i] = ~pref;
    end
  end
endmodule

// File: rtl/thread_pc.sv
module thread_pc #(
  parameter int PC_W        = 32,
  parameter int GRANT_W     = 3,
  parameter int INSTR_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GRANT_W-1:0] grant_next,
  output logic [PC_W-1:0]    pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + PC_W'(grant_next) * PC_W'(INSTR_BYTES);
  end
endmodule

// File: rtl/issue_slot_arbiter.sv
module issue_slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int CNT_W       = 3,
  parameter int PRI_W       = 3,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  localparam int GRANT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0]   thr_ready,
  input  logic [NUM_THREADS-1:0][PRI_W-1:0]   thr_prio,
  input  logic [NUM_THREADS-1:0]              thr_stall,
  output logic [NUM_SLOTS-1:0]                slot_valid,
  output logic [NUM_SLOTS-1:0]                slot_tid,
  output logic [NUM_THREADS-1:0][GRANT_W-1:0] grant_cnt,
  output logic [NUM_THREADS-1:0][PC_W-1:0]    thr_pc
);
  localparam int WGT_W = CNT_W + PRI_W;

  logic [NUM_THREADS-1:0][CNT_W-1:0]   eff_ready;
  logic [NUM_THREADS-1:0][WGT_W-1:0]   weight;
  logic [NUM_THREADS-1:0][GRANT_W-1:0] grant_d;
  tid_t                                pref, rr_q;
  logic                                rr_toggle;
  logic [NUM_SLOTS-1:0]                valid_d;
  tid_t [NUM_SLOTS-1:0]                tid_d;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thread_weight #(.CNT_W(CNT_W), .PRI_W(PRI_W)) u_wgt (
      .ready     (thr_ready[t]),
      .prio      (thr_prio[t]),
      .stall     (thr_stall[t]),
      .eff_ready (eff_ready[t]),
      .weight    (weight[t])
    );
    thread_pc #(.PC_W(PC_W), .GRANT_W(GRANT_W), .INSTR_BYTES(INSTR_BYTES)) u_pc (
      .clk        (clk),
      .rst        (rst),
      .grant_next (grant_d[t]),
      .pc         (thr_pc[t])
    );
  end

  slot_split #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .WGT_W(WGT_W), .GRANT_W(GRANT_W)
  ) u_split (
    .eff_ready (eff_ready),
    .weight    (weight),
    .rr_ptr    (rr_q),
    .pref      (pref),
    .grant     (grant_d),
    .rr_toggle (rr_toggle)
  );

  slot_packer #(.NUM_SLOTS(NUM_SLOTS), .GRANT_W(GRANT_W)) u_pack (
    .pref      (pref),
    .cnt_pref  (grant_d[pref]),
    .cnt_other (grant_d[~pref]),
    .valid     (valid_d),
    .tid       (tid_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q       <= tid_t'(0);
      slot_valid <= '0;
      slot_tid   <= '0;
      grant_cnt  <= '0;
    end else begin
      if (rr_toggle) rr_q <= ~rr_q;
      slot_valid <= valid_d;
      slot_tid   <= tid_d;
      grant_cnt  <= grant_d;
    end
  end
endmodule

// File: rtl/issue_slot_arbiter_chk.sv
module issue_slot_arbiter_chk #(
  parameter int NUM_SLOTS   = 4,
  parameter int CNT_W       = 3,
  parameter int PRI_W       = 3,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  parameter int GRANT_W     = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0][CNT_W-1:0]       thr_ready,
  input logic [1:0][PRI_W-1:0]       thr_prio,
  input logic [1:0]                  thr_stall,
  input logic [NUM_SLOTS-1:0]        slot_valid,
  input logic [NUM_SLOTS-1:0]        slot_tid,
  input logic [1:0][GRANT_W-1:0]     grant_cnt,
  input logic [1:0][PC_W-1:0]        thr_pc
);
  // R1: reset clears slots, grants and counters
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (slot_valid == '0 && grant_cnt == '0 && thr_pc == '0));

  // R6: number of valid slots matches the sum of the grants
  a_r6_count_match: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_valid) == 32'(grant_cnt[0]) + 32'(grant_cnt[1]));

  for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_pack
    // R6: valid slots are contiguous from slot 0
    a_r6_packed: assert property (@(posedge clk) disable iff (rst)
      slot_valid[i] |-> slot_valid[i-1]);
  end

  for (genvar t = 0; t < 2; t++) begin : g_thr
    // R4: stalled thread receives nothing
    a_r4_stall_zero: assert property (@(posedge clk) disable iff (rst)
      thr_stall[t] |=> grant_cnt[t] == '0);
    // R3: grant never exceeds ready count
    a_r3_grant_bound: assert property (@(posedge clk) disable iff (rst)
      !thr_stall[t] |=> 32'(grant_cnt[t]) <= 32'($past(thr_ready[t])));
    // R7: counter steps by grant times instruction size
    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
      !rst |=> thr_pc[t] == PC_W'($past(thr_pc[t]) +
                                  PC_W'(grant_cnt[t]) * PC_W'(INSTR_BYTES)));
  end
endmodule

bind issue_slot_arbiter issue_slot_arbiter_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .PRI_W(PRI_W), .PC_W(PC_W),
  .INSTR_BYTES(INSTR_BYTES), .GRANT_W(GRANT_W)
) u_chk (
  .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_prio(thr_prio),
  .thr_stall(thr_stall), .slot_valid(slot_valid), .slot_tid(slot_tid),
  .grant_cnt(grant_cnt), .thr_pc(thr_pc)
);

// File: tb/issue_slot_arbiter_test.sv
module issue_slot_arbiter_test;
  logic            clk = 1'b0;
  logic            rst;
  logic [1:0][2:0] thr_ready, thr_prio;
  logic [1:0]      thr_stall;
  logic [3:0]      slot_valid, slot_tid;
  logic [1:0][2:0] grant_cnt;
  logic [1:0][31:0] thr_pc;

  int checks = 0;
  int errors = 0;
  logic [31:0] pc_exp [2];

  always #5 clk = ~clk;

  issue_slot_arbiter uut (
    .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_prio(thr_prio),
    .thr_stall(thr_stall), .slot_valid(slot_valid), .slot_tid(slot_tid),
    .grant_cnt(grant_cnt), .thr_pc(thr_pc)
  );

  // {ready0, ready1, prio0, prio1, stall0, stall1, grant0, grant1, first owner}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {3'd3,3'd2,3'd2,3'd2,1'b0,1'b0,3'd3,3'd1,1'b0}, // R2 R3 heavier thread 0
    {3'd1,3'd4,3'd3,3'd1,1'b0,1'b0,3'd0,3'd4,1'b1}, // R2 thread 1 heavier
    {3'd5,3'd7,3'd7,3'd1,1'b0,1'b0,3'd4,3'd0,1'b0}, // R2 full-width 35 vs 7
    {3'd7,3'd2,3'd7,3'd1,1'b1,1'b0,3'd0,3'd2,1'b1}, // R4 thread 0 stalled
    {3'd6,3'd7,3'd1,3'd7,1'b0,1'b1,3'd4,3'd0,1'b0}, // R4 thread 1 stalled
    {3'd2,3'd2,3'd3,3'd3,1'b0,1'b0,3'd2,3'd2,1'b0}, // R5 tie rr=0, toggles
    {3'd2,3'd2,3'd3,3'd3,1'b0,1'b0,3'd2,3'd2,1'b1}, // R5 tie rr=1, toggles
    {3'd4,3'd4,3'd1,3'd1,1'b0,1'b0,3'd4,3'd0,1'b0}, // R5 tie, other empty: hold
    {3'd1,3'd1,3'd2,3'd2,1'b0,1'b0,3'd1,3'd1,1'b0}, // R5 held pointer shows 0
    {3'd3,3'd3,3'd2,3'd2,1'b1,1'b1,3'd0,3'd0,1'b0}, // R9 both stalled
    {3'd3,3'd6,3'd2,3'd1,1'b0,1'b0,3'd0,3'd4,1'b1}, // R5 tie rr=1 one-sided
    {3'd2,3'd2,3'd1,3'd1,1'b0,1'b0,3'd2,3'd2,1'b1}, // R5 pointer still 1
    {3'd5,3'd1,3'd0,3'd1,1'b0,1'b0,3'd3,3'd1,1'b1}, // R3 zero priority leftover
    {3'd0,3'd0,3'd2,3'd2,1'b0,1'b0,3'd0,3'd0,1'b0}, // R9 nothing ready
    {3'd3,3'd1,3'd1,3'd3,1'b0,1'b0,3'd3,3'd1,1'b0}  // R5 R6 tie weights 3=3
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [20:0] v);
    thr_ready[0] = v[20:18]; thr_ready[1] = v[17:15];
    thr_prio[0]  = v[14:12]; thr_prio[1]  = v[11:9];
    thr_stall[0] = v[8];     thr_stall[1] = v[7];
  endtask

  task automatic check_slots(input logic [2:0] g0, input logic [2:0] g1,
                             input logic first);
    logic [3:0] ev = '0, et = '0, mask = '0;
    int gp = first ? int'(g1) : int'(g0);
    int go = first ? int'(g0) : int'(g1);
    for (int i = 0; i < 4; i++) begin
      if (i < gp)           begin ev[i] = 1'b1; et[i] = first;  end
      else if (i < gp + go) begin ev[i] = 1'b1; et[i] = ~first; end
    end
    mask = ev;
    check("R6", "slot_valid", 32'(slot_valid), 32'(ev));
    check("R6", "slot_tid",   32'(slot_tid & mask), 32'(et));
  endtask

  initial begin
    logic [2:0] prev_g0;
    rst = 1'b1;
    drive('0);
    pc_exp[0] = '0; pc_exp[1] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "slot_valid", 32'(slot_valid), 0);
    check("R1", "grant0", 32'(grant_cnt[0]), 0);
    check("R1", "pc0", thr_pc[0], 0);
    check("R1", "pc1", thr_pc[1], 0);
    rst = 1'b0;
    prev_g0 = '0;

    for (int n = 0; n < NV; n++) begin
      drive(VEC[n]);
      #2;
      // R8 outputs still show the previous result before the edge
      check("R8", "grant0 before edge", 32'(grant_cnt[0]), 32'(prev_g0));
      @(negedge clk);
      pc_exp[0] = pc_exp[0] + 32'(VEC[n][6:4]) * 4;
      pc_exp[1] = pc_exp[1] + 32'(VEC[n][3:1]) * 4;
      check("R2/R3/R4/R5", "grant0", 32'(grant_cnt[0]), 32'(VEC[n][6:4]));
      check("R2/R3/R4/R5", "grant1", 32'(grant_cnt[1]), 32'(VEC[n][3:1]));
      check_slots(VEC[n][6:4], VEC[n][3:1], VEC[n][0]);
      check("R7", "pc0", thr_pc[0], pc_exp[0]);
      check("R7", "pc1", thr_pc[1], pc_exp[1]);
      prev_g0 = VEC[n][6:4];
    end

    // R1: pointer is 1 here; reset must clear it and the counters
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "pc0 after reset", thr_pc[0], 0);
    check("R1", "pc1 after reset", thr_pc[1], 0);
    check("R1", "slot_valid after reset", 32'(slot_valid), 0);
    rst = 1'b0;
    drive({3'd2,3'd2,3'd1,3'd1,1'b0,1'b0,3'd0,3'd0,1'b0});
    @(negedge clk);
    check("R1", "tie after reset slot0 owner", 32'(slot_tid[0]), 0);
    check_slots(3'd2, 3'd2, 1'b0);
    check("R7", "pc1 restart", thr_pc[1], 8);

    // R9 both stalled: counters hold across several cycles
    drive({3'd7,3'd7,3'd7,3'd7,1'b1,1'b1,3'd0,3'd0,1'b0});
    repeat (3) @(negedge clk);
    check("R9", "slot_valid idle", 32'(slot_valid), 0);
    check("R9", "pc0 hold", thr_pc[0], 8);
    check("R9", "pc1 hold", thr_pc[1], 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule